// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block is a passive observer placed on a four-wire SPI link between a host and an Ethernet-controller style peripheral that speaks a one-byte command protocol. It samples chip-select, serial clock, MOSI and MISO with the much faster system clock through a short synchronizer. It never drives the bus. Each chip-select-low window is treated as one frame and is cut into whole bytes, most significant bit first, captured on the rising edge of the serial clock (SPI mode 0).

When chip-select returns high after a frame that held at least one complete byte, the monitor emits a one-cycle result strobe. The strobe carries the 3-bit command code and the 5-bit register address from the first byte, the byte count, the MISO byte of the final byte, a MAC/MII class bit and four error flags. Alongside the decode, the monitor keeps its own copy of the peripheral's 2-bit register bank, with a known/unknown bit for each bank bit. It learns the bank from writes, bit-set and bit-clear commands aimed at the bank-select address 0x1F, and from the system reset command. That bank decides whether a register read needs a dummy byte.

Top module: `spi_frame_monitor`

## Requirements
- R1: A frame is the span from a chip-select falling edge to the next rising edge. `res_len_o` is the number of complete 8-bit groups clocked in that span. `res_valid_o` pulses for exactly one cycle per frame. A frame with zero complete bytes produces no strobe.
- R2: `res_cmd_o` is bits 7:5 of the first MOSI byte (0 read register, 1 read buffer, 2 write register, 3 write buffer, 4 bit set, 5 bit clear, 7 system reset). `res_addr_o` is bits 4:0 of that byte. `res_rdata_o` is the MISO byte received during the last complete byte.
- R3: Command code 6 sets error bit 0 (unknown opcode). Every other code leaves that bit clear.
- R4: Write-register, bit-set and bit-clear frames must hold exactly 2 bytes. A system-reset frame must hold exactly 1 byte. Any other length sets error bit 1 (length).
- R5: A read-register frame must hold 3 bytes when the register is in the MAC/MII class, and 2 bytes otherwise. While the bank is not fully known, both 2 and 3 are accepted. Any other length sets error bit 1.
- R6: A read-buffer frame whose first byte is not 0x3A, or a write-buffer frame whose first byte is not 0x7A, sets error bit 2 (header).
- R7: `res_mac_o` is 1 for a register-access command (codes 0, 2, 4, 5) when the bank is fully known and the address is in the MAC/MII set. In bank 2 that set is 0x00, 0x02–0x04, 0x06–0x0B, 0x12, 0x14 and 0x16–0x19. In bank 3 it is 0x00–0x05 and 0x0A. Banks 0 and 1 have no MAC/MII registers.
- R8: A register-access command seen while either bank bit is unknown sets error bit 3 (bank unknown) and reports `res_mac_o` = 0. Both the classification and the flags use the bank as it stood before the frame.
- R9: A write-register frame of valid length to address 0x1F loads the bank from bits 1:0 of the second byte and marks both bits known.
- R10: A bit-set (or bit-clear) frame of valid length to 0x1F sets (or clears) each bank bit whose mask bit in the second byte is 1, and marks only those bits known.
- R11: A system-reset frame of valid length sets the bank to 0 and marks it fully known.
- R12: After reset the bank reads 0 with both known bits 0, and no strobe is issued. A frame with a length error, or one aimed at another address, leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Bus chip-select, active low |
| spi_sclk | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Host-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-host data |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_cmd_o | output | 3 | Command code of the frame |
| res_addr_o | output | 5 | Register address of the frame |
| res_len_o | output | LEN_W | Complete bytes in the frame (saturating) |
| res_err_o | output | 4 | bit0 opcode, bit1 length, bit2 header, bit3 bank unknown |
| res_mac_o | output | 1 | Register is in the MAC/MII class |
| res_rdata_o | output | 8 | MISO byte of the last complete byte |
| bank_o | output | 2 | Tracked register bank |
| bank_known_o | output | 2 | Per-bit known flags of the bank |

## Verification
The result report and the bank update happen on the same clock edge. A frame that rewrites the bank is therefore judged against the old bank, while the bank outputs already show the new one in the strobe cycle. The bench provokes this in two ways. It writes the bank-select address while the bank is unknown, and expects the bank-unknown flag together with a fully known new bank. It then issues register reads straight after bank changes, which must be classified with the bank just written. It also uses partial bit-set masks from the unknown state, which must report the bank as known in only one bit while a following read still raises the bank-unknown flag.

// File: rtl/spi_mon_pkg.sv
// Package: shared command codes, error bit positions and protocol constants
// for the SPI command frame monitor.
package spi_mon_pkg;

    typedef enum logic [2:0] {
        OP_RD_REG  = 3'd0,
        OP_RD_BUF  = 3'd1,
        OP_WR_REG  = 3'd2,
        OP_WR_BUF  = 3'd3,
        OP_BIT_SET = 3'd4,
        OP_BIT_CLR = 3'd5,
        OP_UNUSED  = 3'd6,
        OP_SYS_RST = 3'd7
    } op_e;

    localparam int ERR_W       = 4;
    localparam int ERR_OPCODE  = 0;
    localparam int ERR_LENGTH  = 1;
    localparam int ERR_HEADER  = 2;
    localparam int ERR_BANK    = 3;

    localparam int BANK_W      = 2;
    localparam int ADDR_W      = 5;
    localparam int NUM_BANKS   = 1 << BANK_W;
    localparam int REGS_PER_BK = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] BANK_SEL_ADDR = 5'h1F;
    localparam logic [7:0]        RD_BUF_HDR    = 8'h3A;
    localparam logic [7:0]        WR_BUF_HDR    = 8'h7A;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the four bus pins into the system clock domain through a chain of
// STAGES flops and derives the edge pulses of chip-select and serial clock.
// Assumes the system clock is several times faster than the serial clock, so
// that every serial clock level lasts at least two system clocks.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    input  logic miso,
    output logic cs_fall,
    output logic cs_rise,
    output logic sclk_rise,
    output logic mosi_s,
    output logic miso_s
);
    localparam int PINS = 4;
    // Idle levels: chip-select high, everything else low.
    localparam logic [PINS-1:0] IDLE = 4'b1000;

    logic [PINS-1:0] chain [STAGES];
    logic [PINS-1:0] last_q;

    // First stage: capture the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= IDLE;
        else        chain[0] <= {cs_n, sclk, mosi, miso};
    end

    // Remaining stages: shift through the synchronizer.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= IDLE;
            else        chain[s] <= chain[s-1];
        end
    end

    // Edge detector history: the synchronized value one clock earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IDLE;
        else        last_q <= chain[STAGES-1];
    end

    assign cs_fall   = !chain[STAGES-1][3] &&  last_q[3];
    assign cs_rise   =  chain[STAGES-1][3] && !last_q[3];
    assign sclk_rise =  chain[STAGES-1][2] && !last_q[2];
    assign mosi_s    =  chain[STAGES-1][1];
    assign miso_s    =  chain[STAGES-1][0];

endmodule

// File: rtl/spi_byte_assembler.sv
// Module: spi_byte_assembler
// Shifts MOSI and MISO in, most significant bit first, on each serial clock
// rising edge inside a frame. It counts complete bytes and keeps only what the
// decoder needs: the first MOSI byte, the low two bits of the second MOSI
// byte and the MISO byte of the last complete byte.
// Assumes a chip-select edge and a serial clock rising edge never land on the
// same system clock.
module spi_byte_assembler #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             mosi_s,
    input  logic             miso_s,
    output logic             frame_done,
    output logic [LEN_W-1:0] byte_cnt,
    output logic [7:0]       first_byte,
    output logic [1:0]       sel_bits,
    output logic [7:0]       last_miso
);
    localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

    logic       active;
    logic [2:0] bit_cnt;
    logic [6:0] sh_mosi;
    logic [6:0] sh_miso;
    logic       byte_end;

    assign byte_end   = active && sclk_rise && (bit_cnt == 3'd7);
    assign frame_done = active && cs_rise;

    // Frame window and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            active  <= 1'b1;
            bit_cnt <= '0;
        end else if (cs_rise) begin
            active  <= 1'b0;
        end else if (active && sclk_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // Shift registers for the bits of the byte in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_mosi <= '0;
            sh_miso <= '0;
        end else if (active && sclk_rise) begin
            sh_mosi <= {sh_mosi[5:0], mosi_s};
            sh_miso <= {sh_miso[5:0], miso_s};
        end
    end

    // Saturating count of complete bytes in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) byte_cnt <= '0;
        else if (byte_end && byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
    end

    // Capture of the decoder fields at byte boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_byte <= '0;
            sel_bits   <= '0;
            last_miso  <= '0;
        end else if (byte_end) begin
            if (byte_cnt == '0)                first_byte <= {sh_mosi, mosi_s};
            if (byte_cnt == LEN_W'(1))         sel_bits   <= {sh_mosi[0], mosi_s};
            last_miso <= {sh_miso, miso_s};
        end
    end

endmodule

// File: rtl/spi_frame_decoder.sv
// Module: spi_frame_decoder
// Purely combinational judgement of a finished frame: the command code, the
// register address, the MAC/MII class from a per-bank lookup, the four error
// flags and the bank update request. It uses the bank as it stood before the
// frame.
module spi_frame_decoder
    import spi_mon_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter logic [NUM_BANKS*REGS_PER_BK-1:0] MAC_MAP = '0
) (
    input  logic [7:0]        first_byte,
    input  logic [LEN_W-1:0]  byte_cnt,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANK_W-1:0] known,
    output op_e               op,
    output logic [ADDR_W-1:0] addr,
    output logic [ERR_W-1:0]  err,
    output logic              mac,
    output logic              upd_load,
    output logic              upd_set,
    output logic              upd_clr,
    output logic              upd_zero
);
    logic bank_full;
    logic is_reg;
    logic mac_hit;
    logic len_bad;
    logic to_sel;
    logic [NUM_BANKS-1:0] bank_hit;

    assign op        = op_e'(first_byte[7:5]);
    assign addr      = first_byte[ADDR_W-1:0];
    assign bank_full = &known;
    assign is_reg    = (op == OP_RD_REG) || (op == OP_WR_REG) ||
                       (op == OP_BIT_SET) || (op == OP_BIT_CLR);

    // One lookup slice per bank, each answering for the current address.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_lut
        assign bank_hit[b] = MAC_MAP[b*REGS_PER_BK + int'(addr)];
    end

    assign mac_hit = bank_full && bank_hit[bank];
    assign mac     = is_reg && mac_hit;

    // Length rule per command code.
    always_comb begin
        len_bad = 1'b0;
        unique case (op)
            OP_RD_REG: begin
                if (bank_full)
                    len_bad = mac_hit ? (byte_cnt != LEN_W'(3))
                                      : (byte_cnt != LEN_W'(2));
                else
                    len_bad = (byte_cnt != LEN_W'(2)) && (byte_cnt != LEN_W'(3));
            end
            OP_WR_REG, OP_BIT_SET, OP_BIT_CLR: len_bad = (byte_cnt != LEN_W'(2));
            OP_SYS_RST: len_bad = (byte_cnt != LEN_W'(1));
            default:    len_bad = 1'b0;
        endcase
    end

    // Error flag vector.
    always_comb begin
        err             = '0;
        err[ERR_OPCODE] = (op == OP_UNUSED);
        err[ERR_LENGTH] = len_bad;
        err[ERR_HEADER] = ((op == OP_RD_BUF) && (first_byte != RD_BUF_HDR)) ||
                          ((op == OP_WR_BUF) && (first_byte != WR_BUF_HDR));
        err[ERR_BANK]   = is_reg && !bank_full;
    end

    // Bank update requests, only from frames of valid length.
    assign to_sel   = (addr == BANK_SEL_ADDR) && !len_bad;
    assign upd_load = to_sel && (op == OP_WR_REG);
    assign upd_set  = to_sel && (op == OP_BIT_SET);
    assign upd_clr  = to_sel && (op == OP_BIT_CLR);
    assign upd_zero = !len_bad && (op == OP_SYS_RST);

endmodule

// File: rtl/spi_bank_tracker.sv
// Module: spi_bank_tracker
// Holds the monitor's copy of the peripheral's register bank and a known flag
// per bank bit. Updates only in the cycle a frame is accepted.
module spi_bank_tracker
    import spi_mon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic              upd_load,
    input  logic              upd_set,
    input  logic              upd_clr,
    input  logic              upd_zero,
    input  logic [BANK_W-1:0] operand,
    output logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] known
);
    // Bank state: starts unknown, changes only on accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank  <= '0;
            known <= '0;
        end else if (apply) begin
            if (upd_zero) begin
                bank  <= '0;
                known <= '1;
            end else if (upd_load) begin
                bank  <= operand;
                known <= '1;
            end else if (upd_set) begin
                bank  <= bank | operand;
                known <= known | operand;
            end else if (upd_clr) begin
                bank  <= bank & ~operand;
                known <= known | operand;
            end
        end
    end

endmodule

// File: rtl/spi_frame_monitor.sv
// Module: spi_frame_monitor (top)
// Passive monitor of an SPI command protocol. It synchronizes the bus pins,
// assembles frames into bytes, judges each finished frame and reports it on a
// one-cycle strobe, while tracking the peripheral's register bank.
// Assumes SPI mode 0, MSB first, and a system clock at least four times the
// serial clock.
module spi_frame_monitor
    import spi_mon_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_BANKS*REGS_PER_BK-1:0] MAC_MAP =
        {32'h0000_043F, 32'h03D4_0FDD, 32'h0000_0000, 32'h0000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_miso,
    output logic              res_valid_o,
    output logic [2:0]        res_cmd_o,
    output logic [4:0]        res_addr_o,
    output logic [LEN_W-1:0]  res_len_o,
    output logic [3:0]        res_err_o,
    output logic              res_mac_o,
    output logic [7:0]        res_rdata_o,
    output logic [1:0]        bank_o,
    output logic [1:0]        bank_known_o
);
    logic              cs_fall, cs_rise, sclk_rise, mosi_s, miso_s;
    logic              frame_done;
    logic [LEN_W-1:0]  byte_cnt;
    logic [7:0]        first_byte;
    logic [1:0]        sel_bits;
    logic [7:0]        last_miso;
    op_e               dec_op;
    logic [ADDR_W-1:0] dec_addr;
    logic [ERR_W-1:0]  dec_err;
    logic              dec_mac;
    logic              upd_load, upd_set, upd_clr, upd_zero;
    logic              accept;
    logic [BANK_W-1:0] bank_q, known_q;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .miso      (spi_miso),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .miso_s    (miso_s)
    );

    spi_byte_assembler #(.LEN_W(LEN_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall    (cs_fall),
        .cs_rise    (cs_rise),
        .sclk_rise  (sclk_rise),
        .mosi_s     (mosi_s),
        .miso_s     (miso_s),
        .frame_done (frame_done),
        .byte_cnt   (byte_cnt),
        .first_byte (first_byte),
        .sel_bits   (sel_bits),
        .last_miso  (last_miso)
    );

    spi_frame_decoder #(.LEN_W(LEN_W), .MAC_MAP(MAC_MAP)) u_dec (
        .first_byte (first_byte),
        .byte_cnt   (byte_cnt),
        .bank       (bank_q),
        .known      (known_q),
        .op         (dec_op),
        .addr       (dec_addr),
        .err        (dec_err),
        .mac        (dec_mac),
        .upd_load   (upd_load),
        .upd_set    (upd_set),
        .upd_clr    (upd_clr),
        .upd_zero   (upd_zero)
    );

    // Frames with no complete byte are dropped without a report.
    assign accept = frame_done && (byte_cnt != '0);

    spi_bank_tracker u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (accept),
        .upd_load (upd_load),
        .upd_set  (upd_set),
        .upd_clr  (upd_clr),
        .upd_zero (upd_zero),
        .operand  (sel_bits),
        .bank     (bank_q),
        .known    (known_q)
    );

    // Result strobe: high for the single cycle after a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid_o <= 1'b0;
        else        res_valid_o <= accept;
    end

    // Result fields: held from one accepted frame to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cmd_o   <= '0;
            res_addr_o  <= '0;
            res_len_o   <= '0;
            res_err_o   <= '0;
            res_mac_o   <= 1'b0;
            res_rdata_o <= '0;
        end else if (accept) begin
            res_cmd_o   <= dec_op;
            res_addr_o  <= dec_addr;
            res_len_o   <= byte_cnt;
            res_err_o   <= dec_err;
            res_mac_o   <= dec_mac;
            res_rdata_o <= last_miso;
        end
    end

    assign bank_o       = bank_q;
    assign bank_known_o = known_q;

endmodule

// File: rtl/spi_frame_monitor_chk.sv
// Module: spi_frame_monitor_chk
// Property checker for the frame monitor, bound to every instance of the top.
module spi_frame_monitor_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid_o,
    input logic [2:0]       res_cmd_o,
    input logic [LEN_W-1:0] res_len_o,
    input logic [3:0]       res_err_o,
    input logic             res_mac_o,
    input logic [1:0]       bank_o,
    input logic [1:0]       bank_known_o
);
    // R1: the strobe never lasts two cycles.
    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    // R1: a reported frame always holds at least one byte.
    assert_nonempty_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_len_o != '0));

    // R3: the opcode flag is raised exactly for code 6.
    assert_unknown_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_err_o[0] == (res_cmd_o == 3'd6)));

    // R8: a MAC/MII class is never reported together with an unknown bank.
    assert_class_needs_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !(res_mac_o && res_err_o[3]));

    // R11: an accepted system reset leaves bank 0, fully known.
    assert_reset_cmd_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_cmd_o == 3'd7 && !res_err_o[1]) |->
            (bank_o == 2'd0 && bank_known_o == 2'b11));

    // R12: the bank state only moves together with a result strobe.
    assert_bank_moves_with_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_o != $past(bank_o)) || (bank_known_o != $past(bank_known_o))) |-> res_valid_o);

endmodule

bind spi_frame_monitor spi_frame_monitor_chk #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid_o  (res_valid_o),
    .res_cmd_o    (res_cmd_o),
    .res_len_o    (res_len_o),
    .res_err_o    (res_err_o),
    .res_mac_o    (res_mac_o),
    .bank_o       (bank_o),
    .bank_known_o (bank_known_o)
);

// File: tb/spi_frame_monitor_tb.sv
// Scoreboard bench: the driver predicts each frame's report from the
// requirements and queues it; a monitor pops and compares on every strobe.
module spi_frame_monitor_tb;
    localparam int LEN_W = 8;
    localparam int HALF  = 4;   // system clocks per serial clock half period

    typedef struct {
        logic [2:0] cmd;
        logic [4:0] addr;
        logic [7:0] len;
        logic [3:0] err;
        logic       mac;
        logic [7:0] rdata;
        logic [1:0] bank;
        logic [1:0] known;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, miso = 1'b0;
    logic             res_valid;
    logic [2:0]       res_cmd;
    logic [4:0]       res_addr;
    logic [LEN_W-1:0] res_len;
    logic [3:0]       res_err;
    logic             res_mac;
    logic [7:0]       res_rdata;
    logic [1:0]       bank, known;

    exp_t exp_q [$];
    int   checks = 0;
    int   errors = 0;
    int   strobes = 0;
    logic [1:0] m_bank = 2'b00, m_known = 2'b00;
    bit   done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_frame_monitor #(.LEN_W(LEN_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .spi_cs_n (cs_n), .spi_sclk (sclk), .spi_mosi (mosi), .spi_miso (miso),
        .res_valid_o (res_valid), .res_cmd_o (res_cmd), .res_addr_o (res_addr),
        .res_len_o (res_len), .res_err_o (res_err), .res_mac_o (res_mac),
        .res_rdata_o (res_rdata), .bank_o (bank), .bank_known_o (known)
    );

    // MAC/MII set per bank, written from the address lists in R7.
    function automatic bit in_mac_set(input logic [1:0] bk, input logic [4:0] a);
        if (bk == 2'd2)
            return (a == 5'h00) || (a >= 5'h02 && a <= 5'h04) ||
                   (a >= 5'h06 && a <= 5'h0B) || (a == 5'h12) ||
                   (a == 5'h14) || (a >= 5'h16 && a <= 5'h19);
        if (bk == 2'd3)
            return (a <= 5'h05) || (a == 5'h0A);
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Predict the report of a frame and update the bench's bank model.
    task automatic predict(input int n, input logic [63:0] mv, input logic [63:0] sv,
                           input string tag);
        exp_t e;
        logic [7:0] b0, b1;
        logic [2:0] op;
        bit full, isreg, lbad;
        b0 = mv[63:56];
        b1 = mv[55:48];
        op = b0[7:5];
        full  = (m_known == 2'b11);
        isreg = (op == 3'd0) || (op == 3'd2) || (op == 3'd4) || (op == 3'd5);
        lbad = 1'b0;
        case (op)
            3'd0: lbad = full ? (in_mac_set(m_bank, b0[4:0]) ? (n != 3) : (n != 2))
                              : (n != 2 && n != 3);
            3'd2, 3'd4, 3'd5: lbad = (n != 2);
            3'd7: lbad = (n != 1);
            default: lbad = 1'b0;
        endcase
        e.cmd   = op;
        e.addr  = b0[4:0];
        e.len   = 8'(n);
        e.err   = {isreg && !full,
                   (op == 3'd1 && b0 != 8'h3A) || (op == 3'd3 && b0 != 8'h7A),
                   lbad, op == 3'd6};
        e.mac   = isreg && full && in_mac_set(m_bank, b0[4:0]);
        e.rdata = sv[63-8*(n-1) -: 8];
        if (!lbad) begin
            if (op == 3'd7) begin m_bank = 2'b00; m_known = 2'b11; end
            else if (b0[4:0] == 5'h1F) begin
                if (op == 3'd2) begin m_bank = b1[1:0]; m_known = 2'b11; end
                if (op == 3'd4) begin m_bank = m_bank | b1[1:0]; m_known = m_known | b1[1:0]; end
                if (op == 3'd5) begin m_bank = m_bank & ~b1[1:0]; m_known = m_known | b1[1:0]; end
            end
        end
        e.bank  = m_bank;
        e.known = m_known;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Drive one frame of n bytes, mode 0, MSB first, slave answer on MISO.
    task automatic frame(input int n, input logic [63:0] mv, input logic [63:0] sv,
                         input string tag);
        if (n > 0) predict(n, mv, sv, tag);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            for (int j = 7; j >= 0; j--) begin
                mosi = mv[63-8*i-(7-j)];
                miso = sv[63-8*i-(7-j)];
                repeat (HALF) @(negedge clk);
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_bank = 2'b00;
        m_known = 2'b00;
        @(negedge clk);
    endtask

    // Scoreboard monitor: compare every strobe with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected strobe, act strobe exp none");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_cmd == e.cmd && res_addr == e.addr && res_len == e.len &&
                      res_err == e.err && res_mac == e.mac && res_rdata == e.rdata &&
                      bank == e.bank && known == e.known, e.tag,
                      $sformatf("act cmd=%0d addr=%h len=%0d err=%b mac=%b rd=%h bank=%0d known=%b exp cmd=%0d addr=%h len=%0d err=%b mac=%b rd=%h bank=%0d known=%b",
                                res_cmd, res_addr, res_len, res_err, res_mac, res_rdata, bank, known,
                                e.cmd, e.addr, e.len, e.err, e.mac, e.rdata, e.bank, e.known));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        do_reset();
        // R12: reset state.
        check(!res_valid && bank == 2'b00 && known == 2'b00, "R12",
              $sformatf("reset act valid=%b bank=%0d known=%b exp 0 0 00", res_valid, bank, known));

        // R8 R2: register read while bank unknown.
        frame(2, 64'h0500_0000_0000_0000, 64'h00A5_0000_0000_0000, "R8");
        // R9 R8: bank write from unknown state, judged against old bank.
        frame(2, 64'h5F02_0000_0000_0000, 64'h0, "R9");
        // R5 R7: MAC register read with dummy byte in bank 2.
        frame(3, 64'h0000_0000_0000_0000, 64'h0000_3C00_0000_0000, "R5");
        // R5: MAC register read missing dummy byte.
        frame(2, 64'h0000_0000_0000_0000, 64'h0011_0000_0000_0000, "R5");
        // R7: non-MAC register in bank 2, two bytes.
        frame(2, 64'h0100_0000_0000_0000, 64'h0077_0000_0000_0000, "R7");
        // R10: bit set of mask 01 gives bank 3.
        frame(2, 64'h9F01_0000_0000_0000, 64'h0, "R10");
        // R7 R5: bank 3 MAC register 0x0A.
        frame(3, 64'h0A00_0000_0000_0000, 64'h0000_C300_0000_0000, "R7");
        // R10: bit clear of both bits gives bank 0.
        frame(2, 64'hBF03_0000_0000_0000, 64'h0, "R10");
        // R4 R12: bank write with 3 bytes is a length error, no bank change.
        frame(3, 64'h5F03_0000_0000_0000, 64'h0, "R4");
        // R12: write to another address leaves bank unchanged.
        frame(2, 64'h5E03_0000_0000_0000, 64'h0, "R12");
        // R6: read buffer, good and bad header.
        frame(5, 64'h3A00_0000_0000_0000, 64'h0011_2233_4400_0000, "R6");
        frame(2, 64'h3B00_0000_0000_0000, 64'h0099_0000_0000_0000, "R6");
        // R6: write buffer, good and bad header.
        frame(3, 64'h7A12_3400_0000_0000, 64'h0, "R6");
        frame(1, 64'h7B00_0000_0000_0000, 64'h0, "R6");
        // R3: unused command code.
        frame(1, 64'hC500_0000_0000_0000, 64'h5A00_0000_0000_0000, "R3");
        // R11: system reset with wrong length then correct length.
        frame(2, 64'h5F03_0000_0000_0000, 64'h0, "R9");
        frame(2, 64'hFF00_0000_0000_0000, 64'h0, "R4");
        frame(1, 64'hFF00_0000_0000_0000, 64'h0, "R11");
        // R2: full 8-byte write buffer reports length and last MISO byte.
        frame(8, 64'h7A01_0203_0405_0607, 64'h0000_0000_0000_00E7, "R2");

        // R1: zero-byte frame gives no strobe.
        s0 = strobes;
        frame(0, 64'h0, 64'h0, "R1");
        check(strobes == s0, "R1", $sformatf("empty frame act strobes=%0d exp %0d", strobes - s0, 0));

        // R12 R10: after reset, partial bit set leaves bank half known.
        do_reset();
        check(bank == 2'b00 && known == 2'b00, "R12",
              $sformatf("second reset act bank=%0d known=%b exp 0 00", bank, known));
        frame(2, 64'h9F02_0000_0000_0000, 64'h0, "R10");
        frame(3, 64'h0000_0000_0000_0000, 64'h0, "R8");
        frame(4, 64'h0000_0000_0000_0000, 64'h0, "R5");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R1", $sformatf("pending reports act %0d exp 0", exp_q.size()));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule